// File: doc/BRIEF.md
# Two-Weight Parallel Counter Compressor

This combinational block reduces bits to short binary numbers with parallel counters. A single (10:4) counter turns ten bits of equal weight into the 4-bit count of their ones. A bank of (5,5:4) counters takes five unsigned W-bit operands and compresses them into two words whose sum equals the sum of the five operands. Each counter takes one pair of adjacent columns: five bits of weight 1 and five bits of weight 2. It produces their weighted sum as a 4-bit number, at most 15.

Counter j covers columns 2j and 2j+1 and writes its result to bit positions 2j through 2j+3. Results from even-numbered counters go into the first output word and results from odd-numbered counters go into the second, so no output position is used more than twice. When W is odd, the missing top column is filled with zeros, so every counter still receives a full pair. The final carry-propagate addition of the two words belongs to the consumer of this block.

Top module: `gp_compressor`

## Requirements
- R1: `cnt_val` equals the number of ones in `cnt_bits`, a value from 0 to 10.
- R2: Counter j outputs L + 2*H. L is the number of ones in column 2j across the five operands, and H is the number in column 2j+1. Operand i occupies `opnds[i*W +: W]`.
- R3: The result of counter j is placed at bits 2j to 2j+3 of `word_a` when j is even, and of `word_b` when j is odd. All other bits are zero.
- R4: Bits 1 and 0 of `word_b` are always zero.
- R5: `word_a + word_b`, computed one bit wider than the words, equals the sum of the five operands.
- R6: When W is odd, column W is treated as zero. The top counter's result is then at most 5, and bit 2*ceil(W/2)+1 of both words is zero.
- R7: Each output word is 2*ceil(W/2)+2 bits wide. With all operand bits set and W=8, `word_a` = 0x0FF and `word_b` = 0x3FC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnds | input | 5*W | Five unsigned operands, operand i at bits i*W +: W |
| cnt_bits | input | 10 | Equal-weight bits for the (10:4) counter |
| cnt_val | output | 4 | Count of ones in cnt_bits |
| word_a | output | 2*ceil(W/2)+2 | Results of even-numbered counters |
| word_b | output | 2*ceil(W/2)+2 | Results of odd-numbered counters |

## Verification
The checks assume only that the operands are unsigned and that every input bit is a known 0 or 1. They also assume the checker's sum is one bit wider than the output words, so the addition of the two words cannot wrap. The stimulus keeps to this by driving only fully defined vectors from $urandom and from directed patterns. Both an even width and an odd width are instantiated, so the padded top column is exercised as well as the regular tiling.

// File: rtl/gp_compressor.sv
module gp_compressor #(
  parameter int W = 8
) (
  input  logic [5*W-1:0]             opnds,
  input  logic [9:0]                 cnt_bits,
  output logic [3:0]                 cnt_val,
  output logic [2*((W+1)/2)+1:0]     word_a,
  output logic [2*((W+1)/2)+1:0]     word_b
);
  localparam int P  = (W + 1) / 2;
  localparam int OW = 2 * P + 2;

  function automatic logic [2:0] ones5(input logic [4:0] b);
    logic [2:0] s;
    s = 3'd0;
    for (int i = 0; i < 5; i++) s = s + {2'b00, b[i]};
    return s;
  endfunction

  function automatic logic [3:0] ones10(input logic [9:0] b);
    return {1'b0, ones5(b[4:0])} + {1'b0, ones5(b[9:5])};
  endfunction

  assign cnt_val = ones10(cnt_bits);

  logic [3:0] res [P];

  for (genvar j = 0; j < P; j++) begin : g_pair
    logic [4:0] lo, hi;
    for (genvar i = 0; i < 5; i++) begin : g_op
      assign lo[i] = opnds[i*W + 2*j];
      if (2*j + 1 < W) begin : g_full
        assign hi[i] = opnds[i*W + 2*j + 1];
      end else begin : g_pad
        assign hi[i] = 1'b0;
      end
    end
    assign res[j] = {1'b0, ones5(lo)} + {ones5(hi), 1'b0};
  end

  always_comb begin
    word_a = '0;
    word_b = '0;
    for (int j = 0; j < P; j++) begin
      if (j % 2 == 0) word_a = word_a | (OW'(res[j]) << (2*j));
      else            word_b = word_b | (OW'(res[j]) << (2*j));
    end
  end
endmodule

// File: rtl/gp_compressor_chk.sv
module gp_compressor_chk #(
  parameter int W = 8
) (
  input logic [5*W-1:0]             opnds,
  input logic [9:0]                 cnt_bits,
  input logic [3:0]                 cnt_val,
  input logic [2*((W+1)/2)+1:0]     word_a,
  input logic [2*((W+1)/2)+1:0]     word_b
);
  localparam int OW = 2 * ((W + 1) / 2) + 2;

  logic [OW:0] tot, pair;

  always_comb begin
    tot = '0;
    for (int i = 0; i < 5; i++) tot = tot + (OW+1)'(opnds[i*W +: W]);
    pair = {1'b0, word_a} + {1'b0, word_b};

    a_r1_cnt_range: assert (cnt_val <= 4'd10);
    a_r1_cnt_match: assert (32'(cnt_val) == $countones(cnt_bits));
    a_r4_b_low_zero: assert (word_b[1:0] == 2'b00);
    a_r5_sum_kept: assert (pair == tot);
    if (W % 2 == 1) begin
      a_r6_pad_top: assert (word_a[OW-1] == 1'b0 && word_b[OW-1] == 1'b0);
    end
  end
endmodule

bind gp_compressor gp_compressor_chk #(.W(W)) u_chk (.*);

// File: tb/gp_compressor_bench.sv
module gp_compressor_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int total = 0, bad = 0;

  logic [39:0] ops8;
  logic [24:0] ops5;
  logic [9:0]  cb8, cb5;
  logic [3:0]  cv8, cv5;
  logic [9:0]  wa8, wb8;
  logic [7:0]  wa5, wb5;

  gp_compressor #(.W(8)) u_gp_compressor (
    .opnds(ops8), .cnt_bits(cb8), .cnt_val(cv8), .word_a(wa8), .word_b(wb8));
  gp_compressor #(.W(5)) u_gp_compressor_odd (
    .opnds(ops5), .cnt_bits(cb5), .cnt_val(cv5), .word_a(wa5), .word_b(wb5));

  function automatic logic [15:0] exp_word(input logic [39:0] bus, input int w, input int which);
    logic [15:0] r;
    int p, lo, hi;
    r = '0;
    p = (w + 1) / 2;
    for (int j = 0; j < p; j++) begin
      if (j % 2 == which) begin
        lo = 0; hi = 0;
        for (int i = 0; i < 5; i++) begin
          lo += int'(bus[i*w + 2*j]);
          if (2*j + 1 < w) hi += int'(bus[i*w + 2*j + 1]);
        end
        r = r + (16'(lo + 2*hi) << (2*j));
      end
    end
    return r;
  endfunction

  function automatic int exp_sum(input logic [39:0] bus, input int w);
    int s;
    s = 0;
    for (int i = 0; i < 5; i++)
      for (int c = 0; c < w; c++) s += int'(bus[i*w + c]) << c;
    return s;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all;
    chk("R3 word_a W8", int'(wa8), int'(exp_word(ops8, 8, 0)));
    chk("R3 word_b W8", int'(wb8), int'(exp_word(ops8, 8, 1)));
    chk("R5 sum W8", int'(wa8) + int'(wb8), exp_sum(ops8, 8));
    chk("R4 low bits W8", int'(wb8[1:0]), 0);
    chk("R6 word_a W5", int'(wa5), int'(exp_word({15'd0, ops5}, 5, 0)));
    chk("R6 word_b W5", int'(wb5), int'(exp_word({15'd0, ops5}, 5, 1)));
    chk("R6 pad top W5", int'(wa5[7]) + int'(wb5[7]), 0);
    chk("R5 sum W5", int'(wa5) + int'(wb5), exp_sum({15'd0, ops5}, 5));
  endtask

  initial begin
    int lo, hi;
    bit done;
    done = 0;
    ops8 = '0; ops5 = '0; cb8 = '0; cb5 = '0;
    @(negedge clk);
    chk("R1 zero", int'(cv8), 0);
    chk("R3 zero a", int'(wa8), 0);
    chk("R3 zero b", int'(wb8), 0);

    for (int v = 0; v < 1024; v++) begin
      cb8 = 10'(v);
      cb5 = ~10'(v);
      #1;
      chk("R1 count", int'(cv8), $countones(10'(v)));
      chk("R1 count odd inst", int'(cv5), $countones(~10'(v)));
    end

    for (int v = 0; v < 1024; v++) begin
      ops8 = '0;
      lo = 0; hi = 0;
      for (int i = 0; i < 5; i++) begin
        ops8[i*8]     = v[2*i];
        ops8[i*8 + 1] = v[2*i + 1];
        lo += v[2*i];
        hi += v[2*i + 1];
      end
      #1;
      chk("R2 pair0 weighted", int'(wa8), lo + 2*hi);
      chk("R2 pair0 other word", int'(wb8), 0);
    end

    ops8 = '1; ops5 = '1;
    #1;
    chk("R7 all ones a", int'(wa8), 'h0FF);
    chk("R7 all ones b", int'(wb8), 'h3FC);
    chk("R6 all ones a W5", int'(wa5), 'h5F);
    chk("R6 all ones b W5", int'(wb5), 'h3C);
    chk("R5 all ones sum", int'(wa8) + int'(wb8), 5*255);
    check_all();

    ops8 = {5{8'h10}}; ops5 = {5{5'h10}};
    #1;
    check_all();

    void'($urandom(32'd12345));
    for (int n = 0; n < 3000; n++) begin
      ops8 = {$urandom, 8'($urandom)};
      ops5 = 25'($urandom);
      if (n % 7 == 0) ops8 = ops8 | 40'hFF00FF00FF;
      #1;
      check_all();
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule